// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This block sits on the host side of a parallel flash device. On a start request it first writes a supplied list of command words (address and data pairs) over a simple request/acknowledge bus. It then reads the device's status word at a target address over and over until it can tell whether the embedded program or erase has finished. For chip erase, the caller may supply any address in a sector that is not protected.

Two completion tests are available and an input selects one for each run. The first test compares status bit 7 against bit 7 of the data that was meant to be written. The second test reads twice in a row and looks for a change in bit 6. Status bit 5 flags the device's internal time limit. The completion bits can settle in the same cycle as bit 5, so the block does not trust a busy reading that comes with bit 5 set. It re-checks once and declares failure only if the re-check is still not complete. A programmable cap on the number of poll rounds guards against a device that never answers. Every failure ends with a reset command write, which returns the device to read mode.

A two-bit status output reports the outcome and holds it until the next start.

Top module: `flash_poll_host`

## Requirements
- R1: After reset, status is 0 (idle) and no bus request is raised.
- R2: On start, the block writes command entries 0 to cmdCount-1 in order. Entry i takes its address from cmdAddrFlat[i*AW +: AW] and its data from cmdDataFlat[i*DW +: DW]. It then reads targetAddr. With cmdCount = 0 it goes straight to the read.
- R3: Data mode (toggleMode = 0): a status read whose bit 7 equals targetData[7] ends the run with status 2 (done).
- R4: Data mode: when bit 7 does not match and bit 5 is 1, exactly one more read is made. A match on that read gives done. A mismatch gives failure.
- R5: Toggle mode (toggleMode = 1): reads come in pairs. If bit 6 is equal in both reads of a pair, the run is done. If bit 6 differs and bit 5 of the second read is 0, another pair follows.
- R6: Toggle mode: when bit 6 differs and the second read has bit 5 = 1, exactly one more pair is read. If bit 6 is equal in that pair, the run is done. If it still differs, the run fails.
- R7: When bit 5 is 0 in every evaluation, the run fails after maxPolls evaluations without completion. In data mode an evaluation is one read. In toggle mode it is one pair. A value of 0 acts as 1.
- R8: Every failure writes RST_DATA (default 16'h00F0) to RST_ADDR (default 0). Status becomes 3 (failed) in the cycle after that write is acknowledged.
- R9: Status reads 1 (busy) from start until the outcome is known. It then holds 2 or 3 until the next start. A start while busy is ignored.
- R10: Once busReq is raised, it stays high with busWe, busAddr and busWdata stable until busAck. Each acknowledge completes one transfer, and a read returns its data on busRdata in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| toggleMode | input | 1 | 0 = bit-7 data test, 1 = bit-6 toggle test |
| cmdCount | input | CW | Number of command entries to write |
| cmdAddrFlat | input | NCMD*AW | Packed command addresses, entry 0 in the low bits |
| cmdDataFlat | input | NCMD*DW | Packed command data, entry 0 in the low bits |
| targetAddr | input | AW | Address polled for status |
| targetData | input | DW | Intended data; bit 7 is the expected completion value |
| maxPolls | input | PW | Maximum poll evaluations before failure |
| busReq | output | 1 | Transfer request, held until acknowledge |
| busWe | output | 1 | 1 = write, 0 = read |
| busAddr | output | AW | Transfer address |
| busWdata | output | DW | Write data |
| busAck | input | 1 | Transfer acknowledge |
| busRdata | input | DW | Read data, valid with busAck |
| status | output | 2 | 0 idle, 1 busy, 2 done, 3 failed |

## Verification
The bench builds the block with NCMD = 4, AW = 12, DW = 16 and PW = 8. With those values a full command list and the empty list both fit in a short run, and a poll cap of 3 is reached after only a few reads. A device model answers each read from a queue of scripted status words. Those scripts drive every decision branch: immediate completion, completion after a bit-5 re-check, failure after a re-check, a toggle that stops, a toggle that persists, and exhaustion of the poll cap.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2,
    ST_FAIL = 2'd3
  } run_status_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startCmds;
    logic nextCmd;
    logic issueRead;
    logic issueReset;
    logic latchPrev;
    logic clrPoll;
    logic incPoll;
  } poll_strobes_t;

endpackage

// File: rtl/flash_poll_datapath.sv
module flash_poll_datapath
  import flash_poll_pkg::*;
#(
  parameter int NCMD = 6,
  parameter int AW = 22,
  parameter int DW = 16,
  parameter int PW = 16,
  parameter int CW = $clog2(NCMD + 1),
  parameter logic [AW-1:0] RST_ADDR = '0,
  parameter logic [DW-1:0] RST_DATA = DW'(16'h00F0)
) (
  input  logic               clk,
  input  logic               rstN,
  input  poll_strobes_t      stb,
  input  logic [CW-1:0]      cmdCount,
  input  logic [NCMD*AW-1:0] cmdAddrFlat,
  input  logic [NCMD*DW-1:0] cmdDataFlat,
  input  logic [AW-1:0]      targetAddr,
  input  logic [PW-1:0]      maxPolls,
  input  logic               busAck,
  input  logic [DW-1:0]      busRdata,
  output logic               busReq,
  output logic               busWe,
  output logic [AW-1:0]      busAddr,
  output logic [DW-1:0]      busWdata,
  output logic               cmdNone,
  output logic               cmdLast,
  output logic               pollLast,
  output logic [DW-1:0]      prevRd
);

  logic [CW-1:0] idx;
  logic [PW-1:0] pollCnt;
  int            nextIdx;

  assign nextIdx  = int'(idx) + 1;
  assign cmdNone  = (cmdCount == '0);
  assign cmdLast  = (nextIdx >= int'(cmdCount));
  assign pollLast = ((int'(pollCnt) + 1) >= int'(maxPolls));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx      <= '0;
      pollCnt  <= '0;
      prevRd   <= '0;
      busReq   <= 1'b0;
      busWe    <= 1'b0;
      busAddr  <= '0;
      busWdata <= '0;
    end else begin
      if (busAck) busReq <= 1'b0;
      if (stb.startCmds) begin
        idx      <= '0;
        busReq   <= 1'b1;
        busWe    <= 1'b1;
        busAddr  <= cmdAddrFlat[0 +: AW];
        busWdata <= cmdDataFlat[0 +: DW];
      end
      if (stb.nextCmd) begin
        idx      <= idx + 1'b1;
        busReq   <= 1'b1;
        busWe    <= 1'b1;
        busAddr  <= cmdAddrFlat[nextIdx*AW +: AW];
        busWdata <= cmdDataFlat[nextIdx*DW +: DW];
      end
      if (stb.issueRead) begin
        busReq   <= 1'b1;
        busWe    <= 1'b0;
        busAddr  <= targetAddr;
        busWdata <= '0;
      end
      if (stb.issueReset) begin
        busReq   <= 1'b1;
        busWe    <= 1'b1;
        busAddr  <= RST_ADDR;
        busWdata <= RST_DATA;
      end
      if (stb.clrPoll) pollCnt <= '0;
      else if (stb.incPoll) pollCnt <= pollCnt + 1'b1;
      if (stb.latchPrev) prevRd <= busRdata;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busAddr) && $stable(busWe) && $stable(busWdata)); // R10

  AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.startCmds, stb.nextCmd, stb.issueRead, stb.issueReset})); // R2

endmodule

// File: rtl/flash_poll_control.sv
module flash_poll_control
  import flash_poll_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          toggleMode,
  input  logic [DW-1:0] targetData,
  input  logic          busAck,
  input  logic [DW-1:0] busRdata,
  input  logic          cmdNone,
  input  logic          cmdLast,
  input  logic          pollLast,
  input  logic [DW-1:0] prevRd,
  output poll_strobes_t stb,
  output run_status_t   status
);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_RDA, S_RDB, S_XA, S_XB, S_RST} ctl_state_t;

  ctl_state_t state, stateNx;
  run_status_t statusNx;
  logic modeQ, tgtBit, modeNx, tgtNx;
  logic goDone, goFail;

  always_comb begin
    stb      = '0;
    stateNx  = state;
    statusNx = status;
    modeNx   = modeQ;
    tgtNx    = tgtBit;
    goDone   = 1'b0;
    goFail   = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        statusNx    = ST_BUSY;
        modeNx      = toggleMode;
        tgtNx       = targetData[7];
        stb.clrPoll = 1'b1;
        if (cmdNone) begin
          stb.issueRead = 1'b1;
          stateNx       = S_RDA;
        end else begin
          stb.startCmds = 1'b1;
          stateNx       = S_CMD;
        end
      end
      S_CMD: if (busAck) begin
        if (cmdLast) begin
          stb.issueRead = 1'b1;
          stateNx       = S_RDA;
        end else stb.nextCmd = 1'b1;
      end
      S_RDA: if (busAck) begin
        if (modeQ) begin
          stb.latchPrev = 1'b1;
          stb.issueRead = 1'b1;
          stateNx       = S_RDB;
        end else if (busRdata[7] == tgtBit) goDone = 1'b1;
        else if (busRdata[5]) begin
          stb.issueRead = 1'b1;
          stateNx       = S_XA;
        end else if (pollLast) goFail = 1'b1;
        else begin
          stb.incPoll   = 1'b1;
          stb.issueRead = 1'b1;
        end
      end
      S_RDB: if (busAck) begin
        if (busRdata[6] == prevRd[6]) goDone = 1'b1;
        else if (busRdata[5]) begin
          stb.issueRead = 1'b1;
          stateNx       = S_XA;
        end else if (pollLast) goFail = 1'b1;
        else begin
          stb.incPoll   = 1'b1;
          stb.issueRead = 1'b1;
          stateNx       = S_RDA;
        end
      end
      S_XA: if (busAck) begin
        if (modeQ) begin
          stb.latchPrev = 1'b1;
          stb.issueRead = 1'b1;
          stateNx       = S_XB;
        end else if (busRdata[7] == tgtBit) goDone = 1'b1;
        else goFail = 1'b1;
      end
      S_XB: if (busAck) begin
        if (busRdata[6] == prevRd[6]) goDone = 1'b1;
        else goFail = 1'b1;
      end
      S_RST: if (busAck) begin
        statusNx = ST_FAIL;
        stateNx  = S_IDLE;
      end
      default: stateNx = S_IDLE;
    endcase
    if (goDone) begin
      statusNx = ST_DONE;
      stateNx  = S_IDLE;
    end
    if (goFail) begin
      stb.issueReset = 1'b1;
      stateNx        = S_RST;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      status <= ST_IDLE;
      modeQ  <= 1'b0;
      tgtBit <= 1'b0;
    end else begin
      state  <= stateNx;
      status <= statusNx;
      modeQ  <= modeNx;
      tgtBit <= tgtNx;
    end
  end

  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) && !start |=> $stable(status)); // R9

  AST_BUSY_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |-> (status == ST_BUSY)); // R9

endmodule

// File: rtl/flash_poll_host.sv
module flash_poll_host
  import flash_poll_pkg::*;
#(
  parameter int NCMD = 6,
  parameter int AW = 22,
  parameter int DW = 16,
  parameter int PW = 16,
  parameter int CW = $clog2(NCMD + 1),
  parameter logic [AW-1:0] RST_ADDR = '0,
  parameter logic [DW-1:0] RST_DATA = DW'(16'h00F0)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               toggleMode,
  input  logic [CW-1:0]      cmdCount,
  input  logic [NCMD*AW-1:0] cmdAddrFlat,
  input  logic [NCMD*DW-1:0] cmdDataFlat,
  input  logic [AW-1:0]      targetAddr,
  input  logic [DW-1:0]      targetData,
  input  logic [PW-1:0]      maxPolls,
  output logic               busReq,
  output logic               busWe,
  output logic [AW-1:0]      busAddr,
  output logic [DW-1:0]      busWdata,
  input  logic               busAck,
  input  logic [DW-1:0]      busRdata,
  output logic [1:0]         status
);

  poll_strobes_t stb;
  run_status_t   runStatus;
  logic cmdNone, cmdLast, pollLast;
  logic [DW-1:0] prevRd;

  flash_poll_datapath #(
    .NCMD(NCMD), .AW(AW), .DW(DW), .PW(PW), .CW(CW),
    .RST_ADDR(RST_ADDR), .RST_DATA(RST_DATA)
  ) u_dp (
    .clk, .rstN, .stb, .cmdCount, .cmdAddrFlat, .cmdDataFlat, .targetAddr,
    .maxPolls, .busAck, .busRdata, .busReq, .busWe, .busAddr, .busWdata,
    .cmdNone, .cmdLast, .pollLast, .prevRd
  );

  flash_poll_control #(.DW(DW)) u_ctl (
    .clk, .rstN, .start, .toggleMode, .targetData, .busAck, .busRdata,
    .cmdNone, .cmdLast, .pollLast, .prevRd, .stb, .status(runStatus)
  );

  assign status = runStatus;

  AST_FAIL_AFTER_RESET_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status == ST_FAIL) |-> $past(busAck && busWe && busAddr == RST_ADDR && busWdata == RST_DATA)); // R8

  AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status == ST_DONE) |-> $past(busAck && !busWe)); // R3

endmodule

// File: tb/sim_flash_poll_host.sv
module sim_flash_poll_host;
  localparam int NCMD = 4, AW = 12, DW = 16, PW = 8;
  localparam int CW = $clog2(NCMD + 1);
  localparam logic [AW-1:0] RADDR = '0;
  localparam logic [DW-1:0] RDATA = 16'h00F0;

  logic clk = 0, rstN = 0, start = 0, toggleMode = 0;
  logic [CW-1:0] cmdCount = '0;
  logic [NCMD*AW-1:0] cmdAddrFlat;
  logic [NCMD*DW-1:0] cmdDataFlat;
  logic [AW-1:0] targetAddr = 12'h345;
  logic [DW-1:0] targetData = 16'h0080;
  logic [PW-1:0] maxPolls = 8'd10;
  logic busReq, busWe, busAck = 0;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busWdata, busRdata = '0;
  logic [1:0] status;

  int checks = 0, errors = 0;
  string curReq = "R1";
  logic [DW-1:0] rspQ[$];
  logic [AW+DW:0] expQ[$];

  always #5 clk = ~clk;

  flash_poll_host #(.NCMD(NCMD), .AW(AW), .DW(DW), .PW(PW)) u0 (.*);

  // device model: one-cycle acknowledge, reads served from a script
  always @(posedge clk) begin
    if (busReq && !busAck) begin
      busAck <= 1'b1;
      if (!busWe) busRdata <= (rspQ.size() > 0) ? rspQ.pop_front() : 16'h0000;
    end else busAck <= 1'b0;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: compare each completed transfer with the scoreboard
  logic [AW+DW:0] prevXfer;
  logic prevPend = 0;
  always @(negedge clk) begin
    if (rstN && prevPend) begin
      check({busReq, busWe, busAddr, busWdata} == {1'b1, prevXfer}, "R10", "request changed before ack",
            int'({busWe, busAddr}), int'(prevXfer[AW+DW:DW]));
    end
    prevPend = busReq && !busAck;
    prevXfer = {busWe, busAddr, busWdata};
    if (busAck) begin
      if (expQ.size() == 0) check(0, curReq, "unexpected transfer", int'({busWe, busAddr}), 0);
      else begin
        logic [AW+DW:0] e;
        e = expQ.pop_front();
        check({busWe, busAddr, busWdata} == e, curReq, "transfer", int'({busWe, busAddr, busWdata}), int'(e));
      end
    end
  end

  task automatic expW(input logic [AW-1:0] a, input logic [DW-1:0] d); expQ.push_back({1'b1, a, d}); endtask
  task automatic expR(); expQ.push_back({1'b0, targetAddr, 16'h0000}); endtask
  task automatic expCmds(input int n);
    for (int i = 0; i < n; i++) expW(cmdAddrFlat[i*AW +: AW], cmdDataFlat[i*DW +: DW]);
  endtask
  task automatic expReset(); expW(RADDR, RDATA); endtask

  task automatic runOp(input bit tog, input int n, input string req, input logic [1:0] expSt);
    int waitCnt;
    curReq = req;
    toggleMode = tog;
    cmdCount = CW'(n);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    check(status == 2'd1, "R9", "busy after start", status, 1);
    @(negedge clk) start = 1;   // ignored while busy
    @(negedge clk) start = 0;
    waitCnt = 0;
    while (status == 2'd1 && waitCnt < 2000) begin @(negedge clk); waitCnt++; end
    check(status == expSt, req, "final status", status, expSt);
    check(expQ.size() == 0, req, "transfers left unissued", expQ.size(), 0);
    repeat (5) @(negedge clk);
    check(status == expSt && !busReq, "R9", "status held, bus quiet", status, expSt);
    expQ.delete(); rspQ.delete();
  endtask

  initial begin
    for (int i = 0; i < NCMD; i++) begin
      cmdAddrFlat[i*AW +: AW] = AW'(12'h555 ^ (i * 12'h0FF));
      cmdDataFlat[i*DW +: DW] = DW'(16'h00AA + i * 16'h0011);
    end
    repeat (3) @(negedge clk);
    check(status == 2'd0 && !busReq, "R1", "reset state", {busReq, status}, 0);
    rstN = 1;
    @(negedge clk);

    // R2 R3: full list, one busy read, then bit 7 matches
    expCmds(4); expR(); expR();
    rspQ = '{16'h0000, 16'h0080};
    runOp(0, 4, "R3", 2'd2);

    // R4 R8: bit 5 with mismatch, re-check still mismatched -> reset then fail
    expCmds(2); expR(); expR(); expReset();
    rspQ = '{16'h0020, 16'h0000};
    runOp(0, 2, "R4", 2'd3);

    // R4: bit 5 with mismatch, re-check matches
    expR(); expR();
    rspQ = '{16'h0020, 16'h00A0};
    runOp(0, 0, "R4", 2'd2);

    // R5: toggle pair, then stable pair
    expCmds(1); expR(); expR(); expR(); expR();
    rspQ = '{16'h0040, 16'h0000, 16'h0000, 16'h0000};
    runOp(1, 1, "R5", 2'd2);

    // R6 R8: toggling with bit 5, still toggling -> fail
    expR(); expR(); expR(); expR(); expReset();
    rspQ = '{16'h0040, 16'h0020, 16'h0000, 16'h0040};
    runOp(1, 0, "R6", 2'd3);

    // R6: toggling with bit 5, then stops
    expR(); expR(); expR(); expR();
    rspQ = '{16'h0040, 16'h0020, 16'h0044, 16'h0044};
    runOp(1, 0, "R6", 2'd2);

    // R7: data mode, cap of 3 reads
    maxPolls = 8'd3;
    expR(); expR(); expR(); expReset();
    rspQ = '{16'h0000, 16'h0000, 16'h0000, 16'h0000};
    runOp(0, 0, "R7", 2'd3);

    // R7: toggle mode, cap of 2 pairs
    maxPolls = 8'd2;
    expR(); expR(); expR(); expR(); expReset();
    rspQ = '{16'h0040, 16'h0000, 16'h0040, 16'h0000};
    runOp(1, 0, "R7", 2'd3);

    // R8: toggle data with cap 0 acts as 1
    maxPolls = 8'd0;
    expR(); expR(); expReset();
    rspQ = '{16'h0000, 16'h0040};
    runOp(1, 0, "R8", 2'd3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog expired in %s", curReq);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule